// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block is the control engine that drives a sigma-delta converter through a set of input channels. A channel-enable mask selects the channels. The block visits each enabled channel in turn and wraps back to the lowest one. For every conversion it issues a start strobe that carries the channel number. It counts modulator-clock ticks until the result is due, then raises a result strobe tagged with the channel that produced it. The filter arithmetic and the analog multiplexer are outside the block. The block only decides when each conversion begins and ends.

Timing comes from a filter word FS and a parameter `CLK_PER_FS`, which is the number of modulator ticks per unit of FS (3 × 1024 for a third-order sinc filter).

- One output period is `max(FS,1) × CLK_PER_FS` ticks.
- Settling takes three output periods.

A conversion that follows a channel change resets the filter and waits the full settling time. Repeat conversions on the same channel arrive after one output period. The exception is zero-latency mode, which forces every conversion to settle fully.

The operating mode selects one of four behaviours:

- **Continuous:** the block loops over the enabled channels without stopping.
- **Single:** the block makes one settled conversion on the lowest enabled channel and then parks.
- **Idle and power-down:** both hold the filter in reset and start nothing.

Top module: `conv_sequencer`

## Requirements
- R1: While reset is asserted, and before the first start, `rdy_n` is 1, `conv_start` is 0, `result_valid` is 0 and `filter_rst` is 1.
- R2: In continuous mode the block visits the enabled channels in ascending index order and wraps from the highest enabled channel back to the lowest enabled channel. `start_ch` and `result_ch` carry the channel index.
- R3: A conversion that begins on a channel different from the previous one, or that begins after idle, asserts `filter_rst` together with `conv_start`. Its `result_valid` arrives exactly `3 × max(FS,1) × CLK_PER_FS` ticks of `mclk_tick` after the start.
- R4: Outside zero-latency mode, a conversion that repeats the same channel keeps `filter_rst` low at its start. Its result arrives `max(FS,1) × CLK_PER_FS` ticks after the start.
- R5: With `zero_latency` = 1, every conversion asserts `filter_rst` at its start and takes the full settling time, including same-channel repeats.
- R6: `rdy_n` goes to 1 with each `conv_start` and goes to 0 with each `result_valid`. In continuous mode the next `conv_start` comes on the clock cycle right after `result_valid`. The two strobes never coincide.
- R7: With `op_mode` = 2'b00 (continuous) held through reset, the block begins converting after reset release with no other action needed.
- R8: With `op_mode` = 2'b10 (idle) or 2'b11 (power-down), no `conv_start` is issued and `filter_rst` is held at 1.
- R9: With `op_mode` = 2'b01 (single), the block converts the lowest enabled channel with full settling and then issues no further start. During this wait `rdy_n` stays 0 and `filter_rst` stays 1, until `op_mode` changes.
- R10: With an all-zero `ch_enable`, no `conv_start` and no `result_valid` occur, and `rdy_n` keeps its value.
- R11: A filter word of 0 times conversions as if it were 1.
- R12: Only clock cycles with `mclk_tick` = 1 advance the conversion timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mclk_tick | input | 1 | Modulator clock enable, one tick per modulator clock |
| ch_enable | input | NUM_CH | Channel-enable mask, bit i enables channel i |
| filter_word | input | FS_W | Filter word FS setting the output period |
| zero_latency | input | 1 | Forces full settling on every conversion |
| op_mode | input | 2 | 00 continuous, 01 single, 10 idle, 11 power-down |
| conv_start | output | 1 | One-cycle strobe when a conversion begins |
| start_ch | output | CH_W | Channel of the conversion being started |
| filter_rst | output | 1 | Filter and modulator reset request |
| rdy_n | output | 1 | Active-low result-ready indicator |
| result_valid | output | 1 | One-cycle strobe when a result is due |
| result_ch | output | CH_W | Channel the result belongs to |

## Verification
The bench builds the block with four channels, a 10-bit filter word and `CLK_PER_FS` = 2. With these values a filter word of 3 gives a settling time of 18 ticks and an output period of 6 ticks. A word of 0 gives 6 and 2 ticks. This brings round-robin wrap, same-channel fast repeats, zero latency and the zero filter word into a few hundred cycles. A gated tick pattern of one tick in three shows that settling is counted in modulator ticks and not in system clocks.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    MODE_CONT   = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_IDLE   = 2'b10,
    MODE_PDOWN  = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_NEXT,
    ST_HOLD
  } seq_state_e;

endpackage

// File: rtl/conv_seq_chsel.sv
module conv_seq_chsel #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [CH_W-1:0]   cur_ch,
  output logic [CH_W-1:0]   first_ch,
  output logic [CH_W-1:0]   next_ch,
  output logic              any_en
);

  localparam int SUM_W = CH_W + 1;

  logic [CH_W-1:0]   cand [NUM_CH];
  logic [NUM_CH-1:0] hit;

  // candidate g is the channel g+1 positions after the current one, wrapped
  for (genvar g = 0; g < NUM_CH; g++) begin : g_cand
    logic [SUM_W-1:0] sum;
    assign sum     = {1'b0, cur_ch} + SUM_W'(g + 1);
    assign cand[g] = (sum >= SUM_W'(NUM_CH)) ? CH_W'(sum - SUM_W'(NUM_CH)) : CH_W'(sum);
    assign hit[g]  = ch_enable[cand[g]];
  end

  assign any_en = |ch_enable;

  always_comb begin
    first_ch = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (ch_enable[i]) first_ch = CH_W'(i);
    end
  end

  // nearest enabled candidate wins; the last one is the current channel itself
  always_comb begin
    next_ch = cur_ch;
    for (int g = NUM_CH - 1; g >= 0; g--) begin
      if (hit[g]) next_ch = cand[g];
    end
  end

  p_next_is_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_en |-> ch_enable[next_ch] && ch_enable[first_ch]);

endmodule

// File: rtl/conv_seq_timer.sv
module conv_seq_timer #(
  parameter int FS_W       = 10,
  parameter int CLK_PER_FS = 3072
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            full_i,
  input  logic [FS_W-1:0] fs_i,
  input  logic            active_i,
  input  logic            tick_i,
  output logic            done_o
);

  localparam int MAX_T = 3 * CLK_PER_FS * ((1 << FS_W) - 1);
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [FS_W-1:0]  fs_eff;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign fs_eff = (fs_i == '0) ? FS_W'(1) : fs_i;
  assign period = CNT_W'(fs_eff) * CNT_W'(CLK_PER_FS);
  assign target = full_i ? (period + (period << 1)) : period;

  assign done_o = active_i && tick_i && (cnt_q == CNT_W'(1));
  assign cnt_en = load_i || (active_i && tick_i && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = target;
    else if (cnt_en) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_load_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q != '0);

  p_idle_without_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter  int NUM_CH     = 4,
  parameter  int FS_W       = 10,
  parameter  int CLK_PER_FS = 3072,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk_tick,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [FS_W-1:0]   filter_word,
  input  logic              zero_latency,
  input  logic [1:0]        op_mode,
  output logic              conv_start,
  output logic [CH_W-1:0]   start_ch,
  output logic              filter_rst,
  output logic              rdy_n,
  output logic              result_valid,
  output logic [CH_W-1:0]   result_ch
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  seq_mode_e  mode_in, mode_q;
  seq_state_e state_q, state_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic [CH_W-1:0] start_ch_d, result_ch_d;
  logic            start_d, frst_d, rdy_d, rv_d;
  logic            mode_chg, run_ok;
  logic            t_load, t_full, t_done;
  logic [CH_W-1:0] first_ch, next_ch;
  logic            any_en;

  assign mode_in  = seq_mode_e'(op_mode);
  assign mode_chg = (mode_in != mode_q);
  assign run_ok   = ((mode_in == MODE_CONT) || (mode_in == MODE_SINGLE)) && any_en;

  conv_seq_chsel #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chsel (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .ch_enable(ch_enable),
    .cur_ch   (cur_q),
    .first_ch (first_ch),
    .next_ch  (next_ch),
    .any_en   (any_en)
  );

  conv_seq_timer #(.FS_W(FS_W), .CLK_PER_FS(CLK_PER_FS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .load_i  (t_load),
    .full_i  (t_full),
    .fs_i    (filter_word),
    .active_i(state_q == ST_RUN),
    .tick_i  (mclk_tick),
    .done_o  (t_done)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    cur_d       = cur_q;
    start_d     = 1'b0;
    start_ch_d  = start_ch;
    rdy_d       = rdy_n;
    rv_d        = 1'b0;
    result_ch_d = result_ch;
    t_load      = 1'b0;
    t_full      = 1'b1;

    if (mode_chg) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (run_ok) begin
            start_d    = 1'b1;
            start_ch_d = first_ch;
            cur_d      = first_ch;
            t_load     = 1'b1;
            rdy_d      = 1'b1;
            state_d    = ST_RUN;
          end
        end
        ST_RUN: begin
          if (t_done) begin
            rv_d        = 1'b1;
            result_ch_d = cur_q;
            rdy_d       = 1'b0;
            state_d     = (mode_in == MODE_SINGLE) ? ST_HOLD : ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (!any_en) begin
            state_d = ST_IDLE;
          end else begin
            t_full     = (next_ch != cur_q) || zero_latency;
            start_d    = 1'b1;
            start_ch_d = next_ch;
            cur_d      = next_ch;
            t_load     = 1'b1;
            rdy_d      = 1'b1;
            state_d    = ST_RUN;
          end
        end
        default: state_d = ST_HOLD;
      endcase
    end

    frst_d = (state_d == ST_IDLE) || (state_d == ST_HOLD) || (start_d && t_full);
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q      <= ST_IDLE;
      mode_q       <= MODE_CONT;
      cur_q        <= '0;
      conv_start   <= 1'b0;
      start_ch     <= '0;
      filter_rst   <= 1'b1;
      rdy_n        <= 1'b1;
      result_valid <= 1'b0;
      result_ch    <= '0;
    end else begin
      state_q      <= state_d;
      mode_q       <= mode_in;
      cur_q        <= cur_d;
      conv_start   <= start_d;
      start_ch     <= start_ch_d;
      filter_rst   <= frst_d;
      rdy_n        <= rdy_d;
      result_valid <= rv_d;
      result_ch    <= result_ch_d;
    end
  end

  p_start_result_apart_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(conv_start && result_valid));

  p_rdy_low_with_result_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    result_valid |-> !rdy_n);

  p_quiet_modes_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((op_mode == 2'b10) || (op_mode == 2'b11)) |=> !conv_start);

  p_single_parks_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (result_valid && (op_mode == 2'b01)) |=> !conv_start);

  p_empty_mask_no_start_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ch_enable == '0) |=> !conv_start);

endmodule

// File: tb/conv_sequencer_tb.sv
module conv_sequencer_tb;

  localparam int NUM_CH = 4;
  localparam int FS_W   = 10;
  localparam int CPF    = 2;
  localparam int CH_W   = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mclk_tick;
  logic [NUM_CH-1:0] ch_enable;
  logic [FS_W-1:0]   filter_word;
  logic              zero_latency;
  logic [1:0]        op_mode;
  logic              conv_start;
  logic [CH_W-1:0]   start_ch;
  logic              filter_rst;
  logic              rdy_n;
  logic              result_valid;
  logic [CH_W-1:0]   result_ch;

  int n_tests = 0;
  int n_fail  = 0;
  int tick_total = 0;
  int tick_base  = 0;
  int cyc_base   = 0;
  int cyc        = 0;
  bit gate_ticks = 1'b0;
  int phase      = 0;

  conv_sequencer #(.NUM_CH(NUM_CH), .FS_W(FS_W), .CLK_PER_FS(CPF)) u_dut (
    .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .ch_enable(ch_enable),
    .filter_word(filter_word), .zero_latency(zero_latency), .op_mode(op_mode),
    .conv_start(conv_start), .start_ch(start_ch), .filter_rst(filter_rst),
    .rdy_n(rdy_n), .result_valid(result_valid), .result_ch(result_ch)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mclk_tick) tick_total <= tick_total + 1;
  end

  always @(negedge clk) begin
    phase     <= (phase == 2) ? 0 : phase + 1;
    mclk_tick <= gate_ticks ? (phase == 0) : 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_start(input int ch, input bit frst, input string req);
    int n = 0;
    while (!conv_start && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(conv_start, {req, " start seen"}, conv_start, 1);
    chk(start_ch == CH_W'(ch), {req, " start channel"}, start_ch, ch);
    chk(filter_rst == frst, {req, " filter reset at start"}, filter_rst, frst);
    chk(rdy_n == 1'b1, "R6 rdy high at start", rdy_n, 1);
    tick_base = tick_total;
    cyc_base  = cyc;
  endtask

  task automatic expect_result(input int ch, input int ticks, input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!result_valid && n < 2000);
    chk(result_valid, {req, " result seen"}, result_valid, 1);
    chk(result_ch == CH_W'(ch), {req, " result channel"}, result_ch, ch);
    chk(tick_total - tick_base == ticks, {req, " ticks to result"}, tick_total - tick_base, ticks);
    chk(rdy_n == 1'b0, "R6 rdy low at result", rdy_n, 0);
  endtask

  task automatic back_to_back();
    @(negedge clk);
    chk(conv_start == 1'b1, "R6 next start right after result", conv_start, 1);
  endtask

  task automatic reconfigure(input logic [NUM_CH-1:0] m, input int fs, input bit zl, input bit gate);
    op_mode = 2'b10;
    repeat (3) @(negedge clk);
    ch_enable    = m;
    filter_word  = FS_W'(fs);
    zero_latency = zl;
    gate_ticks   = gate;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; op_mode = 2'b00; ch_enable = 4'b0101; filter_word = 10'd3;
    zero_latency = 1'b0; mclk_tick = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdy_n == 1'b1, "R1 rdy_n in reset", rdy_n, 1);
    chk(conv_start == 1'b0, "R1 conv_start in reset", conv_start, 0);
    chk(result_valid == 1'b0, "R1 result_valid in reset", result_valid, 0);
    chk(filter_rst == 1'b1, "R1 filter_rst in reset", filter_rst, 1);
    rst_n = 1'b1;
  endtask

  task automatic t_round_robin();
    expect_start(0, 1'b1, "R7 R3");
    expect_result(0, 18, "R3");
    back_to_back();
    expect_start(2, 1'b1, "R2");
    expect_result(2, 18, "R3");
    back_to_back();
    expect_start(0, 1'b1, "R2 wrap");
  endtask

  task automatic t_same_channel();
    reconfigure(4'b0010, 3, 1'b0, 1'b0);
    op_mode = 2'b00;
    expect_start(1, 1'b1, "R3");
    expect_result(1, 18, "R3");
    back_to_back();
    expect_start(1, 1'b0, "R4");
    expect_result(1, 6, "R4");
    back_to_back();
    expect_start(1, 1'b0, "R4");
    expect_result(1, 6, "R4");
  endtask

  task automatic t_zero_latency();
    reconfigure(4'b0010, 3, 1'b1, 1'b0);
    op_mode = 2'b00;
    expect_start(1, 1'b1, "R5");
    expect_result(1, 18, "R5");
    back_to_back();
    expect_start(1, 1'b1, "R5 repeat");
    expect_result(1, 18, "R5 repeat");
  endtask

  task automatic t_fs_zero();
    reconfigure(4'b1000, 0, 1'b0, 1'b0);
    op_mode = 2'b00;
    expect_start(3, 1'b1, "R11");
    expect_result(3, 6, "R11 settle");
    back_to_back();
    expect_start(3, 1'b0, "R11");
    expect_result(3, 2, "R11 period");
  endtask

  task automatic t_gated_ticks();
    reconfigure(4'b0001, 3, 1'b0, 1'b1);
    op_mode = 2'b00;
    expect_start(0, 1'b1, "R12");
    expect_result(0, 18, "R12");
    chk(cyc - cyc_base >= 36, "R12 cycles exceed ticks", cyc - cyc_base, 36);
    gate_ticks = 1'b0;
  endtask

  task automatic t_quiet(input logic [1:0] m, input string req);
    int starts = 0, frst_low = 0;
    op_mode = m;
    repeat (3) @(negedge clk);
    repeat (60) begin
      @(negedge clk);
      if (conv_start) starts++;
      if (!filter_rst) frst_low++;
    end
    chk(starts == 0, {req, " starts in quiet mode"}, starts, 0);
    chk(frst_low == 0, {req, " filter_rst released"}, frst_low, 0);
  endtask

  task automatic t_empty_mask();
    logic r0;
    int starts = 0, results = 0, rdy_moves = 0;
    reconfigure(4'b0000, 3, 1'b0, 1'b0);
    r0 = rdy_n;
    op_mode = 2'b00;
    repeat (100) begin
      @(negedge clk);
      if (conv_start) starts++;
      if (result_valid) results++;
      if (rdy_n != r0) rdy_moves++;
    end
    chk(starts == 0, "R10 starts with empty mask", starts, 0);
    chk(results == 0, "R10 results with empty mask", results, 0);
    chk(rdy_moves == 0, "R10 rdy_n changed", rdy_moves, 0);
  endtask

  task automatic t_single();
    int starts = 0, rdy_hi = 0, frst_low = 0;
    reconfigure(4'b1100, 3, 1'b0, 1'b0);
    op_mode = 2'b01;
    expect_start(2, 1'b1, "R9 lowest channel");
    expect_result(2, 18, "R9 settled");
    repeat (80) begin
      @(negedge clk);
      if (conv_start) starts++;
      if (rdy_n) rdy_hi++;
      if (!filter_rst) frst_low++;
    end
    chk(starts == 0, "R9 starts after single", starts, 0);
    chk(rdy_hi == 0, "R9 rdy_n rose while parked", rdy_hi, 0);
    chk(frst_low == 0, "R9 filter_rst low while parked", frst_low, 0);
    op_mode = 2'b00;
    expect_start(2, 1'b1, "R9 restart on mode change");
  endtask

  initial begin
    t_reset();
    t_round_robin();
    t_same_channel();
    t_zero_latency();
    t_fs_zero();
    t_gated_ticks();
    t_quiet(2'b10, "R8 idle");
    t_quiet(2'b11, "R8 power-down");
    t_empty_mask();
    t_single();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule